// File: doc/BRIEF.md
# Calibrated Half-Second Prescaler with Fractional Trim

This block turns a stream of single-cycle enable pulses, taken from a crystal-derived timebase, into a half-second strobe and a one-second strobe for a real-time clock. The period is set by two fields that together act as one 21-bit prescale setting. The 16-bit coarse field sets the whole number of pulses in each half-second period. The 5-bit fine field sets how many periods in every run of 32 get one extra pulse.

A 5-bit accumulator decides which periods are stretched, so the extra pulses are spread evenly and not bunched at the start of the frame. This lets software trim a crystal that runs slightly fast or slow. Raising the fine field lowers the tick rate by a small step, and raising the coarse field lowers it by a large step. Lowering either field does the opposite.

New field values are picked up only at a period boundary, so a running period is never cut short. A toggle halves the half-second strobe to give the one-second strobe.

Top module: `rtc_prescaler`

## Requirements
- R1: With the fine field at 0, every half-second period lasts exactly coarse+1 enable pulses, so a coarse value of 0 gives a strobe after every pulse.
- R2: Counting from reset, with constant settings, each group of 32 consecutive periods holds exactly (fine field) periods of coarse+2 pulses. The remaining periods last coarse+1 pulses, so the group totals 32*(coarse+1)+fine pulses.
- R3: Counting periods from reset as k = 1, 2, ... with fine field F, period k is one pulse longer exactly when floor(k*F/32) exceeds floor((k-1)*F/32).
- R4: `sec_tick` is high together with every second `half_tick` after reset, starting with the second one, and is never high without `half_tick`.
- R5: A change to either field while a period is running does not alter that period. The new values govern the period whose first enable pulse comes after the change, including a change made in the cycle right after a strobe.
- R6: Only enable pulses advance the divider, whatever their spacing. While `en` is low, the count holds and no strobe occurs. `half_tick` rises only in the cycle after the enable pulse that completes a period.
- R7: A synchronous reset holds both strobes low, clears the pulse count, and clears the position in the 32-period frame, so the R3 pattern restarts at k = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Single-cycle pulse from the crystal-derived timebase |
| div_coarse | input | 16 | Coarse divisor; base period is this value plus one pulses |
| div_fine | input | 5 | Fine trim; number of stretched periods per 32 |
| half_tick | output | 1 | One-cycle strobe at the end of each half-second period |
| sec_tick | output | 1 | One-cycle strobe on every second half-second strobe |

## Verification
The assertions check four things on every cycle:
- the one-second strobe never occurs without the half-second strobe;
- a half-second strobe always follows an enable pulse;
- the count holds while enable is low and stays within range;
- the frame accumulator moves only when a period closes.

Only the bench scenarios can show the exact period lengths and the placement of the stretched periods within a 32-period frame. The same holds for alternation of the one-second strobe from reset, the deferral of new field values to the next boundary, and the restart of the frame pattern after a reset in the middle of a run.

// File: rtl/rtc_prescaler_pkg.sv
package rtc_prescaler_pkg;
    localparam int RTC_COARSE_W = 16;
    localparam int RTC_FINE_W   = 5;
endpackage

// File: rtl/rtc_frac_step.sv
module rtc_frac_step #(
    parameter int FINE_W = rtc_prescaler_pkg::RTC_FINE_W
) (
    input  logic [FINE_W-1:0] acc_in,
    input  logic [FINE_W-1:0] trim,
    output logic [FINE_W-1:0] acc_out,
    output logic              stretch
);
    logic [FINE_W:0] sum;

    always_comb begin
        sum     = {1'b0, acc_in} + {1'b0, trim};
        acc_out = sum[FINE_W-1:0];
        stretch = sum[FINE_W];
    end
endmodule

// File: rtl/rtc_second_div.sv
module rtc_second_div (
    input  logic clk,
    input  logic rst,
    input  logic half_strobe,
    output logic sec_tick
);
    typedef struct packed {
        logic phase;
        logic tick;
    } sec_state_t;

    sec_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = half_strobe && s_q.phase;
        if (half_strobe) begin
            s_d.phase = ~s_q.phase;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sec_tick = s_q.tick;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int COARSE_W = rtc_prescaler_pkg::RTC_COARSE_W,
    parameter int FINE_W   = rtc_prescaler_pkg::RTC_FINE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [COARSE_W-1:0] div_coarse,
    input  logic [FINE_W-1:0]   div_fine,
    output logic                half_tick,
    output logic                sec_tick
);
    localparam int CNT_W = COARSE_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [COARSE_W-1:0] coarse_lat;
        logic [FINE_W-1:0]   fine_lat;
        logic [FINE_W-1:0]   acc;
        logic                tick;
    } pre_state_t;

    pre_state_t s_d, s_q;

    logic                at_boundary;
    logic [COARSE_W-1:0] eff_coarse;
    logic [FINE_W-1:0]   eff_fine;
    logic [FINE_W-1:0]   acc_next;
    logic                stretch;
    logic [CNT_W-1:0]    limit;
    logic                period_end;

    // A zero count means no pulse of the current period is counted yet.
    always_comb begin
        at_boundary = (s_q.cnt == '0);
        eff_coarse  = at_boundary ? div_coarse : s_q.coarse_lat;
        eff_fine    = at_boundary ? div_fine   : s_q.fine_lat;
    end

    rtc_frac_step #(.FINE_W(FINE_W)) u_step (
        .acc_in  (s_q.acc),
        .trim    (eff_fine),
        .acc_out (acc_next),
        .stretch (stretch)
    );

    always_comb begin
        limit      = {1'b0, eff_coarse} + {{(CNT_W-1){1'b0}}, stretch};
        period_end = en && (s_q.cnt == limit);

        s_d            = s_q;
        s_d.coarse_lat = eff_coarse;
        s_d.fine_lat   = eff_fine;
        s_d.tick       = period_end;
        if (period_end) begin
            s_d.cnt = '0;
            s_d.acc = acc_next;
        end else if (en) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    rtc_second_div u_sec (
        .clk         (clk),
        .rst         (rst),
        .half_strobe (period_end),
        .sec_tick    (sec_tick)
    );

    assign half_tick = s_q.tick;
endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk #(
    parameter int FINE_W = 5,
    parameter int CNT_W  = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              half_tick,
    input logic              sec_tick,
    input logic [FINE_W-1:0] acc,
    input logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {1'b1, {(CNT_W-1){1'b0}}};

    assert_sec_with_half_R4: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> half_tick);

    assert_tick_after_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        half_tick |-> $past(en));

    assert_hold_without_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

    assert_count_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_MAX);

    assert_frame_moves_at_end_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc) |-> half_tick);
endmodule

bind rtc_prescaler rtc_prescaler_chk #(.FINE_W(FINE_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .half_tick (half_tick),
    .sec_tick  (sec_tick),
    .acc       (s_q.acc),
    .cnt       (s_q.cnt)
);

// File: tb/rtc_prescaler_test.sv
module rtc_prescaler_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [15:0] div_coarse = '0;
    logic [4:0]  div_fine   = '0;
    logic        half_tick;
    logic        sec_tick;

    int n_checks = 0;
    int n_fail   = 0;
    int en_div   = 1;
    int en_count = 0;
    int last_cnt = 0;
    int k_idx    = 0;
    bit phase_m  = 1'b0;

    rtc_prescaler uut (
        .clk(clk), .rst(rst), .en(en),
        .div_coarse(div_coarse), .div_fine(div_fine),
        .half_tick(half_tick), .sec_tick(sec_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) en_count <= 0;
        else if (en) en_count <= en_count + 1;
    end

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (en_div == 0) begin
                en = 1'b0;
            end else begin
                ph = (ph + 1) % en_div;
                en = (ph == 0);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        last_cnt = 0;
        k_idx    = 0;
        phase_m  = 1'b0;
    endtask

    task automatic measure(output int len, output bit sec);
        int guard = 0;
        len = -1;
        sec = 1'b0;
        while (guard < 5000) begin
            @(negedge clk);
            guard++;
            if (half_tick) begin
                len = en_count - last_cnt;
                last_cnt = en_count;
                sec = sec_tick;
                return;
            end
        end
        chk("timeout waiting for half_tick", 0, 1);
    endtask

    // One period against the model; returns its length.
    task automatic expect_period(string tag, int coarse, int fine, output int len);
        bit sec;
        int exp_len;
        k_idx++;
        exp_len = coarse + 1 + (((k_idx * fine) / 32 != ((k_idx - 1) * fine) / 32) ? 1 : 0);
        measure(len, sec);
        chk($sformatf("%s period %0d length", tag, k_idx), len, exp_len);
        chk($sformatf("R4 sec_tick at period %0d", k_idx), int'(sec), int'(phase_m));
        phase_m = ~phase_m;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        en_div = 1;
        div_coarse = 16'd0;
        repeat (4) begin
            @(negedge clk);
            chk("R7 half_tick low in reset", int'(half_tick), 0);
            chk("R7 sec_tick low in reset", int'(sec_tick), 0);
        end
    endtask

    task automatic t_plain();
        int len;
        div_coarse = 16'd9; div_fine = 5'd0; en_div = 1;
        do_reset();
        repeat (6) expect_period("R1 coarse=9", 9, 0, len);
    endtask

    task automatic t_zero();
        int len;
        div_coarse = 16'd0; div_fine = 5'd0; en_div = 1;
        do_reset();
        repeat (5) expect_period("R1 coarse=0", 0, 0, len);
    endtask

    task automatic t_frame(int coarse, int fine);
        int len;
        int total = 0;
        int longs = 0;
        div_coarse = 16'(coarse); div_fine = 5'(fine); en_div = 1;
        do_reset();
        for (int i = 0; i < 32; i++) begin
            expect_period("R3 spread", coarse, fine, len);
            total += len;
            if (len == coarse + 2) longs++;
        end
        chk("R2 stretched periods in frame", longs, fine);
        chk("R2 frame total pulses", total, 32 * (coarse + 1) + fine);
    endtask

    task automatic t_gaps();
        int len;
        div_coarse = 16'd4; div_fine = 5'd8; en_div = 3;
        do_reset();
        repeat (3) expect_period("R6 spaced pulses", 4, 8, len);
        en_div = 0;
        repeat (40) begin
            @(negedge clk);
            chk("R6 no strobe without pulses", int'(half_tick), 0);
        end
        en_div = 5;
        repeat (5) expect_period("R6 resumed pulses", 4, 8, len);
    endtask

    task automatic t_change();
        int len;
        bit sec;
        div_coarse = 16'd7; div_fine = 5'd0; en_div = 1;
        do_reset();
        measure(len, sec);
        chk("R5 first period", len, 8);
        repeat (3) @(negedge clk);
        div_coarse = 16'd2;
        measure(len, sec);
        chk("R5 running period keeps old coarse", len, 8);
        measure(len, sec);
        chk("R5 next period uses new coarse", len, 3);
        div_coarse = 16'd4;
        measure(len, sec);
        chk("R5 change at boundary applies", len, 5);
    endtask

    task automatic t_midreset();
        int len;
        div_coarse = 16'd3; div_fine = 5'd5; en_div = 1;
        do_reset();
        repeat (10) expect_period("R7 before reset", 3, 5, len);
        repeat (2) @(negedge clk);
        do_reset();
        chk("R7 half_tick low after reset", int'(half_tick), 0);
        repeat (9) expect_period("R7 frame restarts", 3, 5, len);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_plain();
        t_zero();
        t_frame(3, 5);
        t_frame(1, 31);
        t_frame(2, 1);
        t_gaps();
        t_change();
        t_midreset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule